// File: doc/BRIEF.md
# Asynchronous Static RAM Access Sequencer

This block lets a clocked system read and write an external asynchronous 2048 x 8 static RAM whose data pins form one shared bidirectional byte bus. The system side offers a single request at a time: it raises `req_i` together with an address, a direction flag and write data while `ready_o` is high. A single-cycle `done_o` pulse marks completion. For a read, the captured byte appears on `rdata_o` in that same cycle.

On the memory side the block drives active-low chip, output and write strobes, an 11-bit address, and a byte bus split into output value, output enable and input value so that a pad cell can form the tri-state. Each timing minimum of the memory is a parameter counted in clock cycles: address setup before the write strobe, write strobe width, data valid before the end of the strobe, hold after the strobe, read access window and bus turnaround. Strobes are held until their count expires and are never cut short. The block owns the data bus only while a write is in progress, and it keeps a guard gap on both sides of every read.

Top module: `sram_ctrl`

## Requirements
- R1: Out of reset and whenever `ready_o` is high, chip enable, output enable and write enable are all high (inactive), the data driver enable is low and `done_o` is low after reset.
- R2: A request is taken only in a cycle where `ready_o` is high. `req_i` raised while `ready_o` is low has no effect on the memory contents.
- R3: The memory address changes only while chip enable is high. It is presented in the same cycle that chip enable falls and stays stable while chip enable is low.
- R4: A write holds chip enable low, write enable high and the data driver on for exactly T_AS cycles before write enable falls.
- R5: Write enable stays low for exactly max(T_WP, T_DW) cycles, with chip enable low, output enable high and the write byte driven and unchanged throughout.
- R6: After write enable rises, address, data drive and chip enable low are held for exactly T_AH cycles. `done_o` pulses T_AS + max(T_WP, T_DW) + T_AH cycles after the accepting edge, and the byte on the bus at the rising write enable is what is stored.
- R7: A read holds chip enable and output enable low with write enable high for exactly T_RD cycles.
- R8: Read data is sampled from `sram_dq_i` in the last cycle of the read window. `done_o` pulses with that byte on `rdata_o` T_RD cycles after the accepting edge.
- R9: The data driver is on only during the write states. It is off for at least one cycle before output enable falls and for at least T_TA cycles after output enable rises.
- R10: After a read, `ready_o` returns T_TA cycles after the `done_o` pulse.
- R11: `done_o` is never high for two consecutive cycles.
- R12: Output enable and write enable are never low together, and write enable is low only while chip enable is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_i | input | 1 | Access request, taken when `ready_o` is high |
| we_i | input | 1 | 1 = write, 0 = read |
| addr_i | input | ADDR_W (11) | Word address |
| wdata_i | input | DATA_W (8) | Byte to write |
| ready_o | output | 1 | Idle and able to take a request |
| done_o | output | 1 | One-cycle completion pulse |
| rdata_o | output | DATA_W (8) | Byte read, valid with `done_o` after a read |
| sram_ce_no | output | 1 | Memory chip enable, active low |
| sram_oe_no | output | 1 | Memory output enable, active low |
| sram_we_no | output | 1 | Memory write enable, active low |
| sram_addr_o | output | ADDR_W (11) | Memory address |
| sram_dq_o | output | DATA_W (8) | Byte driven toward the memory |
| sram_dq_oe_o | output | 1 | Pad driver enable for `sram_dq_o` |
| sram_dq_i | input | DATA_W (8) | Byte received from the memory |

## Verification
Every one of the 2048 addresses is first written with an arithmetic pattern of the address. All are then read back, so address or data bit swaps and stuck lanes show up as pattern mismatches. The memory model returns valid data only from the last cycle of the read window, which separates a correct sampling point from one that comes a cycle early. Each write and read is also timed at the pins: setup, strobe width, hold, completion latency and turnaround are measured per transaction. A request raised in the middle of a busy write targets a different address, and the later read-back shows whether that request was wrongly taken.

// File: rtl/sram_ctrl_pkg.sv
package sram_ctrl_pkg;

  typedef enum logic [2:0] {
    ST_IDLE = 3'd0,
    ST_WSET = 3'd1,
    ST_WPUL = 3'd2,
    ST_WHLD = 3'd3,
    ST_RACC = 3'd4,
    ST_RTRN = 3'd5
  } st_e;

  typedef struct packed {
    logic ce_n;
    logic oe_n;
    logic we_n;
    logic dq_oe;
  } pins_t;

  localparam pins_t PINS_IDLE = '{ce_n: 1'b1, oe_n: 1'b1, we_n: 1'b1, dq_oe: 1'b0};

  function automatic int unsigned max2(int unsigned a, int unsigned b);
    return (a > b) ? a : b;
  endfunction

  // strobe levels per state
  function automatic pins_t pins_of(st_e s);
    pins_t p;
    p = PINS_IDLE;
    unique case (s)
      ST_WSET, ST_WHLD: begin p.ce_n = 1'b0; p.dq_oe = 1'b1; end
      ST_WPUL:          begin p.ce_n = 1'b0; p.dq_oe = 1'b1; p.we_n = 1'b0; end
      ST_RACC:          begin p.ce_n = 1'b0; p.oe_n = 1'b0; end
      default:          p = PINS_IDLE;
    endcase
    return p;
  endfunction

endpackage

// File: rtl/sram_ctrl_timer.sv
module sram_ctrl_timer #(
  parameter int unsigned CW = 4
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          load_i,
  input  logic [CW-1:0] val_i,
  output logic          zero_o
);
  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)            cnt_q <= '0;
    else if (load_i)        cnt_q <= val_i;
    else if (cnt_q != '0)   cnt_q <= cnt_q - 1'b1;
  end

  assign zero_o = (cnt_q == '0);
endmodule

// File: rtl/sram_ctrl_fsm.sv
module sram_ctrl_fsm
  import sram_ctrl_pkg::*;
#(
  parameter int unsigned T_AS = 1,
  parameter int unsigned T_PW = 2,
  parameter int unsigned T_AH = 1,
  parameter int unsigned T_RD = 2,
  parameter int unsigned T_TA = 1,
  parameter int unsigned CW   = 4
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic req_i,
  input  logic we_i,
  output st_e  st_o,
  output st_e  st_nxt_o,
  output logic take_o,
  output logic cap_o,
  output logic wdone_o
);
  st_e           st_q, st_d;
  logic          load;
  logic [CW-1:0] ld_val;
  logic          zero;

  sram_ctrl_timer #(.CW(CW)) u_timer (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .load_i (load),
    .val_i  (ld_val),
    .zero_o (zero)
  );

  always_comb begin
    st_d    = st_q;
    load    = 1'b0;
    ld_val  = '0;
    take_o  = 1'b0;
    cap_o   = 1'b0;
    wdone_o = 1'b0;
    unique case (st_q)
      ST_IDLE: if (req_i) begin
        take_o = 1'b1;
        load   = 1'b1;
        if (we_i) begin st_d = ST_WSET; ld_val = CW'(T_AS - 1); end
        else      begin st_d = ST_RACC; ld_val = CW'(T_RD - 1); end
      end
      ST_WSET: if (zero) begin st_d = ST_WPUL; load = 1'b1; ld_val = CW'(T_PW - 1); end
      ST_WPUL: if (zero) begin st_d = ST_WHLD; load = 1'b1; ld_val = CW'(T_AH - 1); end
      ST_WHLD: if (zero) begin st_d = ST_IDLE; wdone_o = 1'b1; end
      ST_RACC: if (zero) begin
        st_d   = ST_RTRN;
        load   = 1'b1;
        ld_val = CW'(T_TA - 1);
        cap_o  = 1'b1;  // last cycle of the access window
      end
      ST_RTRN: if (zero) st_d = ST_IDLE;
      default: st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) st_q <= ST_IDLE;
    else         st_q <= st_d;
  end

  assign st_o     = st_q;
  assign st_nxt_o = st_d;
endmodule

// File: rtl/sram_ctrl_io.sv
module sram_ctrl_io
  import sram_ctrl_pkg::*;
#(
  parameter int unsigned ADDR_W = 11,
  parameter int unsigned DATA_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  st_e               st_nxt_i,
  input  logic              take_i,
  input  logic              cap_i,
  input  logic              wdone_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic [DATA_W-1:0] dq_i,
  output pins_t             pins_o,
  output logic [ADDR_W-1:0] addr_o,
  output logic [DATA_W-1:0] dq_o,
  output logic [DATA_W-1:0] rdata_o,
  output logic              done_o
);
  pins_t             pins_q;
  logic [ADDR_W-1:0] addr_q;
  logic [DATA_W-1:0] wdata_q, rdata_q;
  logic              done_q;

  // strobes registered from next state: glitch-free, aligned with state
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) pins_q <= PINS_IDLE;
    else         pins_q <= pins_of(st_nxt_i);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      addr_q  <= '0;
      wdata_q <= '0;
    end else if (take_i) begin
      addr_q  <= addr_i;
      wdata_q <= wdata_i;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rdata_q <= '0;
      done_q  <= 1'b0;
    end else begin
      if (cap_i) rdata_q <= dq_i;
      done_q <= cap_i | wdone_i;
    end
  end

  assign pins_o  = pins_q;
  assign addr_o  = addr_q;
  assign dq_o    = wdata_q;
  assign rdata_o = rdata_q;
  assign done_o  = done_q;
endmodule

// File: rtl/sram_ctrl.sv
module sram_ctrl
  import sram_ctrl_pkg::*;
#(
  parameter int unsigned ADDR_W = 11,
  parameter int unsigned DATA_W = 8,
  parameter int unsigned T_AS   = 1,
  parameter int unsigned T_WP   = 2,
  parameter int unsigned T_DW   = 2,
  parameter int unsigned T_AH   = 1,
  parameter int unsigned T_RD   = 2,
  parameter int unsigned T_TA   = 1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_i,
  input  logic              we_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic              ready_o,
  output logic              done_o,
  output logic [DATA_W-1:0] rdata_o,
  output logic              sram_ce_no,
  output logic              sram_oe_no,
  output logic              sram_we_no,
  output logic [ADDR_W-1:0] sram_addr_o,
  output logic [DATA_W-1:0] sram_dq_o,
  output logic              sram_dq_oe_o,
  input  logic [DATA_W-1:0] sram_dq_i
);
  localparam int unsigned T_PW  = max2(T_WP, T_DW);
  localparam int unsigned T_MAX = max2(max2(T_AS, T_PW), max2(max2(T_AH, T_RD), T_TA));
  localparam int unsigned CW    = $clog2(T_MAX + 1) + 1;

  st_e   st, st_nxt;
  logic  take, cap, wdone;
  pins_t pins;

  sram_ctrl_fsm #(
    .T_AS(T_AS), .T_PW(T_PW), .T_AH(T_AH), .T_RD(T_RD), .T_TA(T_TA), .CW(CW)
  ) u_fsm (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .req_i    (req_i),
    .we_i     (we_i),
    .st_o     (st),
    .st_nxt_o (st_nxt),
    .take_o   (take),
    .cap_o    (cap),
    .wdone_o  (wdone)
  );

  sram_ctrl_io #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_io (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .st_nxt_i (st_nxt),
    .take_i   (take),
    .cap_i    (cap),
    .wdone_i  (wdone),
    .addr_i   (addr_i),
    .wdata_i  (wdata_i),
    .dq_i     (sram_dq_i),
    .pins_o   (pins),
    .addr_o   (sram_addr_o),
    .dq_o     (sram_dq_o),
    .rdata_o  (rdata_o),
    .done_o   (done_o)
  );

  assign ready_o      = (st == ST_IDLE);
  assign sram_ce_no   = pins.ce_n;
  assign sram_oe_no   = pins.oe_n;
  assign sram_we_no   = pins.we_n;
  assign sram_dq_oe_o = pins.dq_oe;
endmodule

// File: rtl/sram_ctrl_chk.sv
module sram_ctrl_chk #(
  parameter int unsigned ADDR_W = 11,
  parameter int unsigned T_WP   = 2,
  parameter int unsigned T_DW   = 2
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              ready_o,
  input logic              done_o,
  input logic              sram_ce_no,
  input logic              sram_oe_no,
  input logic              sram_we_no,
  input logic [ADDR_W-1:0] sram_addr_o,
  input logic              sram_dq_oe_o
);
  localparam int unsigned T_PW = (T_WP > T_DW) ? T_WP : T_DW;

  logic [15:0] we_low_cnt;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)          we_low_cnt <= '0;
    else if (!sram_we_no) we_low_cnt <= we_low_cnt + 1'b1;
    else                  we_low_cnt <= '0;
  end

  // R1
  idle_pins_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ready_o |-> (sram_ce_no && sram_oe_no && sram_we_no && !sram_dq_oe_o));

  // R3
  addr_stable_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!sram_ce_no && $past(!sram_ce_no)) |-> $stable(sram_addr_o));

  // R5
  we_width_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(sram_we_no) |-> (we_low_cnt == 16'(T_PW)));

  // R6
  wr_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(sram_we_no) |-> (sram_dq_oe_o && !sram_ce_no));

  // R9
  bus_release_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(sram_oe_no) |-> (!sram_dq_oe_o && $past(!sram_dq_oe_o)));

  // R9
  turnaround_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(sram_dq_oe_o) |-> ($past(sram_oe_no) && $past(sram_oe_no, 2)));

  // R11
  done_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);

  // R12
  strobe_excl_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sram_oe_no || sram_we_no) && (sram_we_no || !sram_ce_no));
endmodule

bind sram_ctrl sram_ctrl_chk #(.ADDR_W(ADDR_W), .T_WP(T_WP), .T_DW(T_DW)) u_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .ready_o      (ready_o),
  .done_o       (done_o),
  .sram_ce_no   (sram_ce_no),
  .sram_oe_no   (sram_oe_no),
  .sram_we_no   (sram_we_no),
  .sram_addr_o  (sram_addr_o),
  .sram_dq_oe_o (sram_dq_oe_o)
);

// File: tb/sram_ctrl_tb.sv
`timescale 1ns/1ps
module sram_ctrl_tb;
  localparam int AW = 11, DW = 8;
  localparam int T_AS = 2, T_WP = 3, T_DW = 2, T_AH = 1, T_RD = 3, T_TA = 2;
  localparam int T_PW = (T_WP > T_DW) ? T_WP : T_DW;
  localparam int WLAT = T_AS + T_PW + T_AH;
  localparam int DEPTH = 1 << AW;

  logic clk = 1'b0, rst_ni = 1'b0;
  logic req = 1'b0, we = 1'b0;
  logic [AW-1:0] addr = '0;
  logic [DW-1:0] wdata = '0;
  logic ready_o, done_o, ce_n, oe_n, we_n, dq_oe;
  logic [DW-1:0] rdata_o, dq_o, dq_i;
  logic [AW-1:0] maddr;

  int checks = 0, fails = 0;
  logic [DW-1:0] mem [DEPTH];
  int oe_cnt = 0;

  always #2 clk = ~clk;

  sram_ctrl #(.ADDR_W(AW), .DATA_W(DW), .T_AS(T_AS), .T_WP(T_WP), .T_DW(T_DW),
              .T_AH(T_AH), .T_RD(T_RD), .T_TA(T_TA)) u_dut (
    .clk_i(clk), .rst_ni(rst_ni), .req_i(req), .we_i(we), .addr_i(addr),
    .wdata_i(wdata), .ready_o(ready_o), .done_o(done_o), .rdata_o(rdata_o),
    .sram_ce_no(ce_n), .sram_oe_no(oe_n), .sram_we_no(we_n), .sram_addr_o(maddr),
    .sram_dq_o(dq_o), .sram_dq_oe_o(dq_oe), .sram_dq_i(dq_i)
  );

  // memory model: data valid only in the final cycle of the read window
  always @(posedge clk) oe_cnt <= oe_n ? 0 : oe_cnt + 1;
  always_comb dq_i = (!ce_n && !oe_n && we_n && oe_cnt >= T_RD - 1) ? mem[maddr] : 8'hEE;

  function automatic logic [DW-1:0] pat(int a);
    return DW'((a * 29 + 7) ^ (a >> 3));
  endfunction

  task automatic check(bit ok, string tag, int act, int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
    end
  endtask

  // pin-level monitor
  logic p_ce = 1, p_oe = 1, p_we = 1, p_dqoe = 0;
  logic [AW-1:0] p_addr = '0;
  logic [DW-1:0] p_dq = '0;
  int setup_run = 0, we_run = 0, hold_run = 0, oe_run = 0, gap = 1000;
  bit post = 0;
  int addr_viol = 0, bus_viol = 0, strobe_viol = 0;

  always @(negedge clk) if (rst_ni) begin
    if (!ce_n && !p_ce && maddr != p_addr) addr_viol++;
    if (!oe_n && !we_n) strobe_viol++;
    if (!we_n && ce_n) strobe_viol++;
    if (!we_n && !oe_n) strobe_viol++;
    if (!oe_n && (dq_oe || p_dqoe)) bus_viol++;
    if (dq_oe && p_dqoe && dq_o != p_dq) bus_viol++;
    if (!oe_n) gap = 0; else if (!dq_oe) gap++;
    if (dq_oe && !p_dqoe && gap < T_TA) bus_viol++;
    // read window
    if (!oe_n) begin
      if (ce_n || !we_n) strobe_viol++;
      oe_run++;
    end
    if (oe_n && !p_oe) begin check(oe_run == T_RD, "R7", oe_run, T_RD); oe_run = 0; end
    // write phases
    if (ce_n) setup_run = 0; else if (we_n && dq_oe && !post) setup_run++;
    if (!we_n && p_we) begin check(setup_run == T_AS, "R4", setup_run, T_AS); we_run = 0; end
    if (!we_n) we_run++;
    if (we_n && !p_we) begin
      check(we_run == T_PW, "R5", we_run, T_PW);
      check(dq_oe && !ce_n, "R6", dq_oe, 1);
      mem[maddr] = dq_o;
      post = 1; hold_run = 0;
    end
    if (post && !ce_n && we_n) hold_run++;
    if (ce_n && !p_ce && post) begin check(hold_run == T_AH, "R6", hold_run, T_AH); post = 0; end
    p_ce = ce_n; p_oe = oe_n; p_we = we_n; p_dqoe = dq_oe; p_addr = maddr; p_dq = dq_o;
  end

  task automatic do_op(bit w, int a, logic [DW-1:0] d, output logic [DW-1:0] rd);
    int c;
    @(negedge clk);
    while (!ready_o) @(negedge clk);
    req = 1; we = w; addr = AW'(a); wdata = d;
    @(negedge clk);
    req = 0; c = 0;
    while (!done_o && c < 100) begin @(negedge clk); c++; end
    if (w) check(c == WLAT, "R6", c, WLAT);
    else   check(c == T_RD, "R8", c, T_RD);
    rd = rdata_o;
    @(negedge clk);
    check(!done_o, "R11", done_o, 0);
    if (!w) begin
      c = 1;
      while (!ready_o && c < 100) begin @(negedge clk); c++; end
      check(c == T_TA, "R10", c, T_TA);
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    logic [DW-1:0] rd;
    int c;
    repeat (5) @(posedge clk);
    @(negedge clk);
    // R1 reset state
    check(ce_n && oe_n && we_n && !dq_oe, "R1", {ce_n, oe_n, we_n, dq_oe}, 4'b1110);
    check(ready_o && !done_o, "R1", {ready_o, done_o}, 2'b10);
    rst_ni = 1;
    @(negedge clk);
    check(ready_o && ce_n && oe_n && we_n && !dq_oe, "R1", ready_o, 1);

    // sweep writes then reads over every address
    for (int a = 0; a < DEPTH; a++) do_op(1'b1, a, pat(a), rd);
    for (int a = 0; a < DEPTH; a++) begin
      do_op(1'b0, a, 8'h00, rd);
      check(rd == pat(a), "R8", rd, pat(a));
    end

    // R2: request raised while busy must be ignored
    @(negedge clk);
    req = 1; we = 1; addr = AW'(5); wdata = 8'h11;
    @(negedge clk);
    check(!ready_o, "R2", ready_o, 0);
    addr = AW'(6); wdata = 8'h99;
    @(negedge clk);
    req = 0;
    c = 0;
    while (!done_o && c < 100) begin @(negedge clk); c++; end
    check(c == WLAT - 1, "R2", c, WLAT - 1);
    @(negedge clk);
    check(!done_o, "R11", done_o, 0);
    do_op(1'b0, 6, 8'h00, rd);
    check(rd == pat(6), "R2", rd, pat(6));
    do_op(1'b0, 5, 8'h00, rd);
    check(rd == 8'h11, "R6", rd, 8'h11);

    // alternating read/write at the top and bottom addresses
    do_op(1'b1, DEPTH - 1, 8'h5A, rd);
    do_op(1'b0, DEPTH - 1, 8'h00, rd);
    check(rd == 8'h5A, "R8", rd, 8'h5A);
    do_op(1'b1, 0, 8'hA5, rd);
    do_op(1'b0, 0, 8'h00, rd);
    check(rd == 8'hA5, "R8", rd, 8'hA5);

    repeat (4) @(negedge clk);
    check(addr_viol == 0, "R3", addr_viol, 0);
    check(bus_viol == 0, "R9", bus_viol, 0);
    check(strobe_viol == 0, "R12", strobe_viol, 0);
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule